// File: doc/BRIEF.md
# I2C Second-Address Match and Arbitration-Loss Status Flags

This block keeps two sticky status bits for an I2C controller. The first bit reports that the first byte received after a START carried a second programmable 7-bit slave address while the controller was a slave receiver. The second bit reports that the controller lost arbitration while it was a master transmitter. The block finds this by comparing the levels it drives on SDA and SCL with the levels seen on the wires.

The surrounding controller supplies several inputs: the synchronized wire levels, the values it is driving, its mode, the received first byte together with a completion strobe, and a START strobe. Software sees both bits on a small status bus. A bit is cleared by reading it as 1 and then writing 0 to it. Each bit also has hardware events that clear it on their own. The block does no bit shifting, no START/STOP decoding and no driving of the bus.

Top module: `i2c_status_flags`

## Requirements
- R1: After synchronous reset, `addr2_hit`, `arb_lost` and `stat_rdata` are all 0.
- R2: When `frame1_done` is high in slave receive mode (`master_mode`=0, `transmit_mode`=0), `addr2_disable`=0 and `frame1_addr` equals `own_addr2`, `addr2_hit` is 1 from the next cycle. A mismatching address or any other mode leaves it 0.
- R3: While `addr2_disable` is 1, a matching first byte does not set `addr2_hit`.
- R4: `start_det` clears `addr2_hit` in the next cycle. It also wins over a match strobe in the same cycle.
- R5: While `master_mode` is 1, `addr2_hit` is cleared and cannot set.
- R6: In master transmit mode (`master_mode`=1, `transmit_mode`=1), a rising edge of `scl_pin` sets `arb_lost` when `sda_drive` differs from `sda_pin` in that cycle. A rising edge is a cycle where `scl_pin` is 1 and it was 0 in the previous cycle; the previous level is taken as 1 after reset. `arb_lost` is 1 from the next cycle.
- R7: In master transmit mode, a falling edge of `scl_pin` while `scl_drive` is 1 sets `arb_lost`.
- R8: Outside master transmit mode, or when the driven levels agree with the wire, `arb_lost` does not set.
- R9: `data_wr` with `transmit_mode`=1 clears `arb_lost`, and so does `data_rd` with `transmit_mode`=0. `data_rd` with `transmit_mode`=1 has no effect. A set event in the same cycle wins.
- R10: A `stat_rd` while a bit is 1 arms that bit. A later `stat_wr` with a 0 in the bit's position clears an armed bit. Writing 0 to an unarmed bit does nothing, and writing 1 never sets a bit or disarms it.
- R11: A new set event for a bit disarms it, so a write of 0 after that event leaves the bit at 1 until it is read again.
- R12: `stat_rdata` bit 1 is `addr2_hit` and bit 0 is `arb_lost`. The same positions apply to `stat_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_pin | input | 1 | Synchronized SCL wire level |
| sda_pin | input | 1 | Synchronized SDA wire level |
| scl_drive | input | 1 | SCL level this controller drives (1 = released) |
| sda_drive | input | 1 | SDA level this controller drives (1 = released) |
| master_mode | input | 1 | Controller is bus master |
| transmit_mode | input | 1 | Controller is transmitting |
| addr2_disable | input | 1 | Disables recognition of the second address |
| own_addr2 | input | ADDR_W | Second slave address |
| frame1_done | input | 1 | First byte after START received (strobe) |
| frame1_addr | input | ADDR_W | Address bits of that first byte |
| start_det | input | 1 | START condition detected (strobe) |
| stat_rd | input | 1 | Status register read strobe |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 2 | Status write data (bit1 address flag, bit0 arbitration flag) |
| data_rd | input | 1 | Data register read strobe |
| data_wr | input | 1 | Data register write strobe |
| addr2_hit | output | 1 | Second address recognized |
| arb_lost | output | 1 | Arbitration lost |
| stat_rdata | output | 2 | Status read data |

## Verification
The hardest case to reach is the disarm race. A bit must already be 1 and armed by a read, then receive a fresh set event before the write of 0 arrives. For the arbitration bit this also needs a correctly timed SCL edge while the controller is a master transmitter. Directed sequences build this case step by step. Long random runs then mix status reads and writes, SCL toggles, mode changes and data-register accesses against a cycle model in the bench, so that the same-cycle collisions of set, hardware clear and software clear also appear.

// File: rtl/i2c_flag_pkg.sv
package i2c_flag_pkg;

    localparam int ADDR_W   = 7;
    localparam int STAT_W   = 2;
    localparam int IDX_ARB  = 0;
    localparam int IDX_ADDR = 1;

    // Mode is {master, transmit}
    typedef enum logic [1:0] {
        MODE_SLV_RX = 2'b00,
        MODE_SLV_TX = 2'b01,
        MODE_MST_RX = 2'b10,
        MODE_MST_TX = 2'b11
    } bus_mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } scl_edge_t;

    // Events feeding one sticky flag
    typedef struct packed {
        logic set_ev;
        logic hw_clr;
    } flag_evt_t;

    function automatic bus_mode_e mode_of(input logic master, input logic transmit);
        return bus_mode_e'({master, transmit});
    endfunction

    function automatic logic is_master(input bus_mode_e m);
        return (m == MODE_MST_RX) || (m == MODE_MST_TX);
    endfunction

endpackage

// File: rtl/scl_edge_det.sv
module scl_edge_det
    import i2c_flag_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_i,
    output scl_edge_t edges_o
);

    // Registered copy of the wire; the idle bus level is high
    logic scl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
        end
    end

    always_comb begin
        edges_o.rise = scl_i & ~scl_q;
        edges_o.fall = ~scl_i & scl_q;
    end

endmodule

// File: rtl/addr2_match.sv
module addr2_match
    import i2c_flag_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  bus_mode_e        mode_i,
    input  logic             disable_i,
    input  logic [AW-1:0]    own_addr_i,
    input  logic             frame_done_i,
    input  logic [AW-1:0]    frame_addr_i,
    input  logic             start_i,
    output flag_evt_t        evt_o
);

    logic addr_eq;
    logic recog_ok;

    always_comb begin
        addr_eq  = (frame_addr_i == own_addr_i);
        recog_ok = (mode_i == MODE_SLV_RX) && !disable_i;
        evt_o.set_ev = frame_done_i && recog_ok && addr_eq;
        // START or master operation wipes the flag (this variant clears first)
        evt_o.hw_clr = start_i || is_master(mode_i);
    end

endmodule

// File: rtl/arb_monitor.sv
module arb_monitor
    import i2c_flag_pkg::*;
(
    input  bus_mode_e  mode_i,
    input  scl_edge_t  edges_i,
    input  logic       sda_drive_i,
    input  logic       sda_pin_i,
    input  logic       scl_drive_i,
    input  logic       data_wr_i,
    input  logic       data_rd_i,
    output flag_evt_t  evt_o
);

    logic sda_clash;
    logic scl_clash;
    logic tx_side;

    always_comb begin
        tx_side   = (mode_i == MODE_SLV_TX) || (mode_i == MODE_MST_TX);
        // Another master pulled SDA low while this one released it (or the reverse)
        sda_clash = edges_i.rise && (sda_drive_i != sda_pin_i);
        // SCL dropped while this master still released it
        scl_clash = edges_i.fall && scl_drive_i;
        evt_o.set_ev = (mode_i == MODE_MST_TX) && (sda_clash || scl_clash);
        // Data register access acknowledges the loss
        evt_o.hw_clr = (tx_side && data_wr_i) || (!tx_side && data_rd_i);
    end

endmodule

// File: rtl/sticky_flag.sv
module sticky_flag
    import i2c_flag_pkg::*;
#(
    parameter bit CLR_OVER_SET = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  flag_evt_t evt_i,
    input  logic      stat_rd_i,
    input  logic      stat_wr_i,
    input  logic      wr_bit_i,
    output logic      flag_o
);

    logic flag_q, armed_q;
    logic flag_d, armed_d;
    logic sw_clear;

    assign sw_clear = stat_wr_i && !wr_bit_i && armed_q;

    generate
        if (CLR_OVER_SET) begin : g_clr_first
            always_comb begin
                flag_d  = flag_q;
                armed_d = armed_q;
                if (evt_i.hw_clr) begin
                    flag_d  = 1'b0;
                    armed_d = 1'b0;
                end else if (evt_i.set_ev) begin
                    flag_d  = 1'b1;
                    armed_d = 1'b0;
                end else if (sw_clear) begin
                    flag_d  = 1'b0;
                    armed_d = 1'b0;
                end else if (stat_rd_i && flag_q) begin
                    armed_d = 1'b1;
                end
            end
        end else begin : g_set_first
            always_comb begin
                flag_d  = flag_q;
                armed_d = armed_q;
                if (evt_i.set_ev) begin
                    flag_d  = 1'b1;
                    armed_d = 1'b0;
                end else if (evt_i.hw_clr) begin
                    flag_d  = 1'b0;
                    armed_d = 1'b0;
                end else if (sw_clear) begin
                    flag_d  = 1'b0;
                    armed_d = 1'b0;
                end else if (stat_rd_i && flag_q) begin
                    armed_d = 1'b1;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            flag_q  <= flag_d;
            armed_q <= armed_d;
        end
    end

    assign flag_o = flag_q;

    // R10: a write of 0 to an unarmed, undisturbed flag leaves it set
    a_r10_unarmed_write: assert property (@(posedge clk) disable iff (rst)
        (flag_q && stat_wr_i && !armed_q && !evt_i.set_ev && !evt_i.hw_clr) |=> flag_q);

    // R10: writing 1 never removes the flag
    a_r10_write_one_keeps: assert property (@(posedge clk) disable iff (rst)
        (flag_q && stat_wr_i && wr_bit_i && !evt_i.hw_clr) |=> flag_q);

    // R11: a set event that is not overridden leaves the flag up and disarmed
    a_r11_set_disarms: assert property (@(posedge clk) disable iff (rst)
        (evt_i.set_ev && !(CLR_OVER_SET && evt_i.hw_clr)) |=> (flag_q && !armed_q));

endmodule

// File: rtl/i2c_status_flags.sv
module i2c_status_flags
    import i2c_flag_pkg::*;
#(
    parameter int ADDR_BITS = ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scl_pin,
    input  logic                 sda_pin,
    input  logic                 scl_drive,
    input  logic                 sda_drive,
    input  logic                 master_mode,
    input  logic                 transmit_mode,
    input  logic                 addr2_disable,
    input  logic [ADDR_BITS-1:0] own_addr2,
    input  logic                 frame1_done,
    input  logic [ADDR_BITS-1:0] frame1_addr,
    input  logic                 start_det,
    input  logic                 stat_rd,
    input  logic                 stat_wr,
    input  logic [STAT_W-1:0]    stat_wdata,
    input  logic                 data_rd,
    input  logic                 data_wr,
    output logic                 addr2_hit,
    output logic                 arb_lost,
    output logic [STAT_W-1:0]    stat_rdata
);

    bus_mode_e   mode;
    scl_edge_t   scl_edges;
    flag_evt_t   evts [STAT_W];
    logic [STAT_W-1:0] flags;

    assign mode = mode_of(master_mode, transmit_mode);

    scl_edge_det u_edge (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl_pin),
        .edges_o (scl_edges)
    );

    addr2_match #(.AW(ADDR_BITS)) u_match (
        .mode_i       (mode),
        .disable_i    (addr2_disable),
        .own_addr_i   (own_addr2),
        .frame_done_i (frame1_done),
        .frame_addr_i (frame1_addr),
        .start_i      (start_det),
        .evt_o        (evts[IDX_ADDR])
    );

    arb_monitor u_arb (
        .mode_i      (mode),
        .edges_i     (scl_edges),
        .sda_drive_i (sda_drive),
        .sda_pin_i   (sda_pin),
        .scl_drive_i (scl_drive),
        .data_wr_i   (data_wr),
        .data_rd_i   (data_rd),
        .evt_o       (evts[IDX_ARB])
    );

    // One sticky cell per status bit; the address bit lets its hardware clear win
    generate
        for (genvar i = 0; i < STAT_W; i++) begin : g_flag
            sticky_flag #(.CLR_OVER_SET(i == IDX_ADDR)) u_flag (
                .clk       (clk),
                .rst       (rst),
                .evt_i     (evts[i]),
                .stat_rd_i (stat_rd),
                .stat_wr_i (stat_wr),
                .wr_bit_i  (stat_wdata[i]),
                .flag_o    (flags[i])
            );
        end
    endgenerate

    assign addr2_hit  = flags[IDX_ADDR];
    assign arb_lost   = flags[IDX_ARB];
    assign stat_rdata = flags;

    // R2: a new address recognition needs a matching first byte in slave receive
    a_r2_match_source: assert property (@(posedge clk) disable iff (rst)
        $rose(addr2_hit) |-> $past(frame1_done && !master_mode && !transmit_mode
                                   && (frame1_addr == own_addr2)));

    // R3: recognition is blocked while disabled
    a_r3_disable_blocks: assert property (@(posedge clk) disable iff (rst)
        $rose(addr2_hit) |-> $past(!addr2_disable));

    // R4: START removes the address flag
    a_r4_start_clears: assert property (@(posedge clk) disable iff (rst)
        start_det |=> !addr2_hit);

    // R5: master operation removes the address flag
    a_r5_master_clears: assert property (@(posedge clk) disable iff (rst)
        master_mode |=> !addr2_hit);

    // R8: arbitration loss only arises as master transmitter
    a_r8_only_mst_tx: assert property (@(posedge clk) disable iff (rst)
        $rose(arb_lost) |-> $past(master_mode && transmit_mode));

    // R9: a data read in receive mode acknowledges the loss
    a_r9_rx_read_clears: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !transmit_mode) |=> !arb_lost);

endmodule

// File: tb/tb_i2c_status_flags.sv
module tb_i2c_status_flags;

    logic clk = 1'b0;
    logic rst;
    logic scl_pin, sda_pin, scl_drive, sda_drive;
    logic master_mode, transmit_mode, addr2_disable;
    logic [6:0] own_addr2, frame1_addr;
    logic frame1_done, start_det, stat_rd, stat_wr, data_rd, data_wr;
    logic [1:0] stat_wdata;
    logic addr2_hit, arb_lost;
    logic [1:0] stat_rdata;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    i2c_status_flags dut (
        .clk(clk), .rst(rst),
        .scl_pin(scl_pin), .sda_pin(sda_pin),
        .scl_drive(scl_drive), .sda_drive(sda_drive),
        .master_mode(master_mode), .transmit_mode(transmit_mode),
        .addr2_disable(addr2_disable), .own_addr2(own_addr2),
        .frame1_done(frame1_done), .frame1_addr(frame1_addr),
        .start_det(start_det), .stat_rd(stat_rd), .stat_wr(stat_wr),
        .stat_wdata(stat_wdata), .data_rd(data_rd), .data_wr(data_wr),
        .addr2_hit(addr2_hit), .arb_lost(arb_lost), .stat_rdata(stat_rdata)
    );

    // Cycle model built from the requirements
    logic m_scl, m_addr, m_arb, m_arm_a, m_arm_b;
    logic t_rise, t_fall, t_seta, t_clra, t_setb, t_clrb;

    always @(posedge clk) begin
        if (rst) begin
            m_scl <= 1'b1; m_addr <= 1'b0; m_arb <= 1'b0;
            m_arm_a <= 1'b0; m_arm_b <= 1'b0;
        end else begin
            t_rise = scl_pin && !m_scl;
            t_fall = !scl_pin && m_scl;
            t_seta = frame1_done && !master_mode && !transmit_mode && !addr2_disable
                     && (frame1_addr == own_addr2);
            t_clra = start_det || master_mode;
            t_setb = master_mode && transmit_mode &&
                     ((t_rise && (sda_drive != sda_pin)) || (t_fall && scl_drive));
            t_clrb = (data_wr && transmit_mode) || (data_rd && !transmit_mode);
            m_scl <= scl_pin;
            if (t_clra) begin m_addr <= 1'b0; m_arm_a <= 1'b0; end
            else if (t_seta) begin m_addr <= 1'b1; m_arm_a <= 1'b0; end
            else if (stat_wr && !stat_wdata[1] && m_arm_a) begin m_addr <= 1'b0; m_arm_a <= 1'b0; end
            else if (stat_rd && m_addr) m_arm_a <= 1'b1;
            if (t_setb) begin m_arb <= 1'b1; m_arm_b <= 1'b0; end
            else if (t_clrb) begin m_arb <= 1'b0; m_arm_b <= 1'b0; end
            else if (stat_wr && !stat_wdata[0] && m_arm_b) begin m_arb <= 1'b0; m_arm_b <= 1'b0; end
            else if (stat_rd && m_arb) m_arm_b <= 1'b1;
        end
    end

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic strobes_off();
        frame1_done = 0; start_det = 0; stat_rd = 0; stat_wr = 0;
        data_rd = 0; data_wr = 0; stat_wdata = 2'b00;
    endtask

    // Inputs are set at a falling edge; one rising edge passes; outputs read at the next falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        strobes_off();
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; strobes_off();
        scl_pin = 1; sda_pin = 1; scl_drive = 1; sda_drive = 1;
        master_mode = 0; transmit_mode = 0; addr2_disable = 0;
        own_addr2 = 7'h5A; frame1_addr = 7'h00;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 flags", {addr2_hit, arb_lost}, 2'b00);
        chk("R1 status", stat_rdata, 2'b00);

        // Address recognition
        frame1_done = 1; frame1_addr = 7'h5A; tick();
        chk("R2 match sets", {1'b0, addr2_hit}, 2'b01);
        stat_wr = 1; stat_wdata = 2'b00; tick();
        chk("R10 unarmed write0", {1'b0, addr2_hit}, 2'b01);
        stat_rd = 1; tick();
        stat_wr = 1; stat_wdata = 2'b11; tick();
        chk("R10 write1 keeps", {1'b0, addr2_hit}, 2'b01);
        stat_wr = 1; stat_wdata = 2'b00; tick();
        chk("R10 armed write0 clears", {1'b0, addr2_hit}, 2'b00);
        frame1_done = 1; frame1_addr = 7'h5B; tick();
        chk("R2 mismatch", {1'b0, addr2_hit}, 2'b00);
        addr2_disable = 1; frame1_done = 1; frame1_addr = 7'h5A; tick();
        chk("R3 disabled", {1'b0, addr2_hit}, 2'b00);
        addr2_disable = 0;
        transmit_mode = 1; frame1_done = 1; frame1_addr = 7'h5A; tick();
        chk("R2 slave tx no set", {1'b0, addr2_hit}, 2'b00);
        transmit_mode = 0;
        frame1_done = 1; frame1_addr = 7'h5A; start_det = 1; tick();
        chk("R4 start beats set", {1'b0, addr2_hit}, 2'b00);
        frame1_done = 1; frame1_addr = 7'h5A; tick();
        start_det = 1; tick();
        chk("R4 start clears", {1'b0, addr2_hit}, 2'b00);
        frame1_done = 1; frame1_addr = 7'h5A; tick();
        master_mode = 1; tick();
        chk("R5 master clears", {1'b0, addr2_hit}, 2'b00);
        frame1_done = 1; frame1_addr = 7'h5A; tick();
        chk("R5 master blocks", {1'b0, addr2_hit}, 2'b00);

        // Arbitration (master transmit)
        transmit_mode = 1;
        scl_pin = 0; scl_drive = 0; tick();
        chk("R7 fall with low drive", {1'b0, arb_lost}, 2'b00);
        sda_drive = 1; sda_pin = 0; scl_pin = 1; scl_drive = 1; tick();
        chk("R6 sda clash at rise", {1'b0, arb_lost}, 2'b01);
        chk("R12 status bit0", stat_rdata, 2'b01);
        sda_pin = 1;
        data_rd = 1; tick();
        chk("R9 tx read no clear", {1'b0, arb_lost}, 2'b01);
        data_wr = 1; tick();
        chk("R9 tx write clears", {1'b0, arb_lost}, 2'b00);
        scl_pin = 0; tick();
        chk("R7 fall with high drive", {1'b0, arb_lost}, 2'b01);
        transmit_mode = 0; data_rd = 1; tick();
        chk("R9 rx read clears", {1'b0, arb_lost}, 2'b00);
        sda_drive = 1; sda_pin = 0; scl_pin = 1; tick();
        chk("R8 master rx no set", {1'b0, arb_lost}, 2'b00);
        transmit_mode = 1; scl_pin = 0; scl_drive = 0; tick();
        sda_drive = 0; sda_pin = 0; scl_pin = 1; scl_drive = 1; tick();
        chk("R8 levels agree", {1'b0, arb_lost}, 2'b00);
        scl_pin = 0; tick();
        stat_rd = 1; tick();
        sda_drive = 1; sda_pin = 0; scl_pin = 1; tick();
        stat_wr = 1; stat_wdata = 2'b00; tick();
        chk("R11 set disarms", {1'b0, arb_lost}, 2'b01);
        stat_rd = 1; tick();
        stat_wr = 1; stat_wdata = 2'b10; tick();
        chk("R12 write bit0 clears arb", {1'b0, arb_lost}, 2'b00);
        sda_pin = 1; scl_pin = 0; data_wr = 1; tick();
        chk("R9 set beats clear", {1'b0, arb_lost}, 2'b01);
        master_mode = 0; transmit_mode = 0;
        frame1_done = 1; frame1_addr = 7'h5A; tick();
        chk("R12 both bits", stat_rdata, 2'b11);

        // Random mix against the model
        for (int n = 0; n < 6000; n++) begin
            if ($urandom_range(99) < 8)  master_mode   = $urandom_range(1);
            if ($urandom_range(99) < 8)  transmit_mode = $urandom_range(1);
            if ($urandom_range(99) < 5)  addr2_disable = $urandom_range(1);
            if ($urandom_range(99) < 35) scl_pin = ~scl_pin;
            scl_drive   = $urandom_range(1);
            sda_drive   = $urandom_range(1);
            sda_pin     = $urandom_range(1);
            frame1_done = ($urandom_range(99) < 20);
            frame1_addr = ($urandom_range(1) == 1) ? own_addr2 : 7'($urandom_range(127));
            start_det   = ($urandom_range(99) < 5);
            stat_rd     = ($urandom_range(99) < 30);
            stat_wr     = ($urandom_range(99) < 25);
            stat_wdata  = 2'($urandom_range(3));
            data_rd     = ($urandom_range(99) < 8);
            data_wr     = ($urandom_range(99) < 8);
            tick();
            chk("R10 model flags", {addr2_hit, arb_lost}, {m_addr, m_arb});
            chk("R12 model status", stat_rdata, {m_addr, m_arb});
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule